// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block observes the two interrupt mask bits of a processor core, the ordinary mask (I) and the extended mask (X). It measures, in clock cycles, how long each bit remains set. For each bit it runs its own tracker. The tracker opens an interval on the first cycle the bit is sampled high and stores the cycle count at that moment. When the bit is next sampled low, the tracker closes the interval and folds its length into shortest, longest and most recent statistics.

All trackers share one free-running cycle counter. The counter sticks at all-ones instead of wrapping, so an interval that outlasts the counter range reports a saturated length and never a wrapped one. A query strobe lets an observer fold a still-open interval into the longest statistic before reading it. Until a bit has completed an interval, its shortest statistic reads back as the longest one, so it never shows the all-ones placeholder.

Top module: `mask_span_monitor`

## Requirements
- R1: After reset, every min, max and last output of both bits reads 0 and both open flags read 0.
- R2: The rising edge of the clock that first samples a mask bit high opens that bit's interval and records the current cycle count. Later high samples do not re-record it, so the length counts from the first high sample.
- R3: The first edge that samples the bit low while it is open closes the interval. Last becomes the number of edges that sampled the bit high, and the open flag clears. Last, min and max are visible after that edge and change at no other edge.
- R4: A closed interval of length L sets min to the smaller of min and L, and max to the larger of max and L. Last is therefore never above max.
- R5: The I bit and the X bit have separate trackers. Activity on one bit leaves every output of the other bit unchanged.
- R6: An edge that samples query high while a bit's interval is open raises that bit's max to the running length (current count minus recorded start) if that is larger. With no open interval, or with a smaller running length, query has no effect. Max never decreases.
- R7: While a bit's internal min still holds its all-ones reset value, its min output shows the max value instead, so min never reads above max.
- R8: The cycle counter starts at 0 after reset and sticks at all-ones (2^CNT_W - 1). An interval opened on the first edge after reset and held past that point closes with length all-ones.
- R9: If query is high on the edge that closes an interval, max ends as the larger of its prior value and the closing length. Last still takes the closing length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_mask | input | 1 | Ordinary interrupt mask bit |
| x_mask | input | 1 | Extended interrupt mask bit |
| query | input | 1 | Fold open intervals into max on this edge |
| i_min | output | CNT_W | Shortest closed I interval (max when none) |
| i_max | output | CNT_W | Longest I interval seen or queried |
| i_last | output | CNT_W | Most recent closed I interval |
| i_open | output | 1 | An I interval is open |
| x_min | output | CNT_W | Shortest closed X interval (max when none) |
| x_max | output | CNT_W | Longest X interval seen or queried |
| x_last | output | CNT_W | Most recent closed X interval |
| x_open | output | 1 | An X interval is open |

## Verification
The query fold and the interval close can hit the same clock edge, and both then compete to update max. A directed case drops the I bit and raises query in the same cycle. It is judged by max and last both equalling the closing length, and by the max not growing past that length. The random phase raises query on about one cycle in eight while both bits toggle freely, so the two updates collide many times. A model in the bench checks every output after every edge.

// File: rtl/msm_pkg.sv
package msm_pkg;

    // Number of mask bits watched; index order is fixed by the top level.
    parameter int unsigned MSM_NUM_BITS = 2;

    typedef enum logic [0:0] {
        MSK_I = 1'b0,
        MSK_X = 1'b1
    } msk_sel_e;

endpackage

// File: rtl/msm_cycle_ctr.sv
module msm_cycle_ctr #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] now
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign now = cnt_q;
endmodule

// File: rtl/msm_min_view.sv
module msm_min_view #(
    parameter int unsigned CNT_W = 32
) (
    input  logic [CNT_W-1:0] lo_raw,
    input  logic [CNT_W-1:0] hi,
    output logic [CNT_W-1:0] lo_shown
);
    localparam logic [CNT_W-1:0] UNSET = {CNT_W{1'b1}};

    always_comb begin
        lo_shown = lo_raw;
        if (lo_raw == UNSET) begin
            lo_shown = hi;
        end
    end
endmodule

// File: rtl/msm_span_tracker.sv
module msm_span_tracker #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask,
    input  logic             query,
    input  logic [CNT_W-1:0] now,
    output logic [CNT_W-1:0] lo,
    output logic [CNT_W-1:0] hi,
    output logic [CNT_W-1:0] last,
    output logic             open
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] last;
    } trk_t;

    trk_t st_d, st_q;
    logic [CNT_W-1:0] run_len;
    logic             closing;
    logic             folding;

    always_comb begin
        st_d    = st_q;
        run_len = now - st_q.start;
        closing = st_q.open && !mask;
        folding = st_q.open && (query || !mask);

        if (!st_q.open && mask) begin
            st_d.open  = 1'b1;
            st_d.start = now;
        end

        if (folding && (run_len > st_q.hi)) begin
            st_d.hi = run_len;
        end

        if (closing) begin
            st_d.open = 1'b0;
            st_d.last = run_len;
            if (run_len < st_q.lo) begin
                st_d.lo = run_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.open  <= 1'b0;
            st_q.start <= '0;
            st_q.lo    <= ALL1;
            st_q.hi    <= '0;
            st_q.last  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo   = st_q.lo;
    assign hi   = st_q.hi;
    assign last = st_q.last;
    assign open = st_q.open;
endmodule

// File: rtl/mask_span_monitor.sv
module mask_span_monitor #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_mask,
    input  logic             x_mask,
    input  logic             query,
    output logic [CNT_W-1:0] i_min,
    output logic [CNT_W-1:0] i_max,
    output logic [CNT_W-1:0] i_last,
    output logic             i_open,
    output logic [CNT_W-1:0] x_min,
    output logic [CNT_W-1:0] x_max,
    output logic [CNT_W-1:0] x_last,
    output logic             x_open
);
    import msm_pkg::*;

    localparam int unsigned NB = MSM_NUM_BITS;

    logic [CNT_W-1:0] cyc_now;
    logic [NB-1:0]    mask_v;
    logic [NB-1:0]    open_v;
    logic [CNT_W-1:0] lo_raw_v [NB];
    logic [CNT_W-1:0] lo_v     [NB];
    logic [CNT_W-1:0] hi_v     [NB];
    logic [CNT_W-1:0] last_v   [NB];

    assign mask_v[MSK_I] = i_mask;
    assign mask_v[MSK_X] = x_mask;

    msm_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .now  (cyc_now)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bit
        msm_span_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk  (clk),
            .rst_n(rst_n),
            .mask (mask_v[b]),
            .query(query),
            .now  (cyc_now),
            .lo   (lo_raw_v[b]),
            .hi   (hi_v[b]),
            .last (last_v[b]),
            .open (open_v[b])
        );

        msm_min_view #(.CNT_W(CNT_W)) u_view (
            .lo_raw  (lo_raw_v[b]),
            .hi      (hi_v[b]),
            .lo_shown(lo_v[b])
        );
    end

    assign i_min  = lo_v[MSK_I];
    assign i_max  = hi_v[MSK_I];
    assign i_last = last_v[MSK_I];
    assign i_open = open_v[MSK_I];
    assign x_min  = lo_v[MSK_X];
    assign x_max  = hi_v[MSK_X];
    assign x_last = last_v[MSK_X];
    assign x_open = open_v[MSK_X];
endmodule

// File: rtl/msm_checker.sv
module msm_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_mask,
    input logic             x_mask,
    input logic [CNT_W-1:0] cyc_now,
    input logic [CNT_W-1:0] i_min,
    input logic [CNT_W-1:0] i_max,
    input logic [CNT_W-1:0] i_last,
    input logic             i_open,
    input logic [CNT_W-1:0] x_min,
    input logic [CNT_W-1:0] x_max,
    input logic [CNT_W-1:0] x_last,
    input logic             x_open
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    p_open_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(i_open) |-> $past(i_mask));
    p_open_on_high_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_open) |-> $past(x_mask));
    p_close_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(i_open) |-> !$past(i_mask));
    p_close_on_low_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(x_open) |-> !$past(x_mask));
    p_last_only_on_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(i_open) |-> $stable(i_last));
    p_last_only_on_close_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(x_open) |-> $stable(x_last));
    p_last_le_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (i_last <= i_max) && (x_last <= x_max));
    p_max_never_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_max >= $past(i_max)) && (x_max >= $past(x_max)));
    p_min_le_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (i_min <= i_max) && (x_min <= x_max));
    p_cnt_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_now == ALL1) |=> (cyc_now == ALL1));
endmodule

bind mask_span_monitor msm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .i_mask (i_mask),
    .x_mask (x_mask),
    .cyc_now(cyc_now),
    .i_min  (i_min),
    .i_max  (i_max),
    .i_last (i_last),
    .i_open (i_open),
    .x_min  (x_min),
    .x_max  (x_max),
    .x_last (x_last),
    .x_open (x_open)
);

// File: tb/sim_mask_span_monitor.sv
module sim_mask_span_monitor;
    localparam int unsigned W = 16;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_mask = 1'b0, x_mask = 1'b0, query = 1'b0;
    logic [W-1:0] i_min, i_max, i_last, x_min, x_max, x_last;
    logic i_open, x_open;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mask_span_monitor #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .i_mask(i_mask), .x_mask(x_mask), .query(query),
        .i_min(i_min), .i_max(i_max), .i_last(i_last), .i_open(i_open),
        .x_min(x_min), .x_max(x_max), .x_last(x_last), .x_open(x_open)
    );

    // Bench model built from the requirements, index 0 = I, 1 = X.
    logic [W-1:0] m_cnt;
    logic         m_open  [2];
    logic [W-1:0] m_start [2];
    logic [W-1:0] m_lo    [2];
    logic [W-1:0] m_hi    [2];
    logic [W-1:0] m_last  [2];

    always @(posedge clk) begin
        logic [1:0] mk;
        logic [W-1:0] len;
        mk = {x_mask, i_mask};
        if (!rst_n) begin
            m_cnt = '0;
            for (int b = 0; b < 2; b++) begin
                m_open[b] = 0; m_start[b] = '0; m_lo[b] = ALL1; m_hi[b] = '0; m_last[b] = '0;
            end
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (m_open[b]) begin
                    len = m_cnt - m_start[b];
                    if ((query || !mk[b]) && len > m_hi[b]) m_hi[b] = len;
                    if (!mk[b]) begin
                        m_last[b] = len;
                        if (len < m_lo[b]) m_lo[b] = len;
                        m_open[b] = 0;
                    end
                end else if (mk[b]) begin
                    m_open[b] = 1;
                    m_start[b] = m_cnt;
                end
            end
            if (m_cnt != ALL1) m_cnt = m_cnt + 1'b1;
        end
    end

    function automatic logic [W-1:0] exp_min(int b);
        return (m_lo[b] == ALL1) ? m_hi[b] : m_lo[b];
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R4 i_min"},  i_min,  exp_min(0));
        chk({tag, " R6 i_max"},  i_max,  m_hi[0]);
        chk({tag, " R3 i_last"}, i_last, m_last[0]);
        chk({tag, " R2 i_open"}, W'(i_open), W'(m_open[0]));
        chk({tag, " R5 x_min"},  x_min,  exp_min(1));
        chk({tag, " R5 x_max"},  x_max,  m_hi[1]);
        chk({tag, " R5 x_last"}, x_last, m_last[1]);
        chk({tag, " R5 x_open"}, W'(x_open), W'(m_open[1]));
    endtask

    // Check at the falling edge, then drive the inputs for the next rising edge.
    task automatic cyc(logic i, logic x, logic q, bit do_chk = 1);
        @(negedge clk);
        if (do_chk) check_all("model");
        i_mask = i; x_mask = x; query = q;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        chk("R1 i_min", i_min, 0); chk("R1 i_max", i_max, 0); chk("R1 i_last", i_last, 0);
        chk("R1 x_min", x_min, 0); chk("R1 x_max", x_max, 0); chk("R1 x_last", x_last, 0);
        chk("R1 opens", W'({i_open, x_open}), 0);

        // R7: X open 10 edges, query on the 10th -> max 9, min shows max
        repeat (9) cyc(0, 1, 0);
        cyc(0, 1, 1);
        cyc(0, 0, 0);
        chk("R7 x_max running", x_max, 9);
        chk("R7 x_min fallback", x_min, 9);
        chk("R7 x_last untouched", x_last, 0);
        cyc(0, 0, 0);
        chk("R3 x_last 10", x_last, 10);
        chk("R4 x_min 10", x_min, 10);

        // R2/R3: I high 5 edges
        repeat (5) cyc(1, 0, 0);
        cyc(0, 0, 0);
        chk("R3 i_last before close edge", i_last, 0);
        cyc(0, 0, 0);
        chk("R3 i_last 5", i_last, 5);
        chk("R2 i_open cleared", W'(i_open), 0);

        // R5: X 3 edges, I untouched
        repeat (3) cyc(0, 1, 0);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R5 x_last 3", x_last, 3);
        chk("R5 x_min 3", x_min, 3);
        chk("R5 i_last kept", i_last, 5);
        chk("R5 i_max kept", i_max, 5);

        // R4: I 8 then 2
        repeat (8) cyc(1, 0, 0);
        cyc(0, 0, 0);
        repeat (2) cyc(1, 0, 0);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R4 i_min 2", i_min, 2);
        chk("R4 i_max 8", i_max, 8);
        chk("R4 i_last 2", i_last, 2);

        // R6: query with nothing open has no effect
        cyc(0, 0, 1); cyc(0, 0, 0);
        chk("R6 idle query i_max", i_max, 8);
        chk("R6 idle query x_max", x_max, 10);

        // R6: query on 15th high edge -> running 14
        repeat (14) cyc(1, 0, 0);
        cyc(1, 0, 1);
        cyc(1, 0, 0);
        chk("R6 fold i_max 14", i_max, 14);
        chk("R6 fold i_last kept", i_last, 2);
        repeat (4) cyc(1, 0, 0);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R3 i_last 20", i_last, 20);
        chk("R4 i_max 20", i_max, 20);

        // R9: close and query on the same edge, length 30
        repeat (30) cyc(1, 0, 0);
        cyc(0, 0, 1); cyc(0, 0, 0);
        chk("R9 i_last 30", i_last, 30);
        chk("R9 i_max 30", i_max, 30);
        chk("R9 i_min 2", i_min, 2);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic ni, nx, nq;
            ni = (($urandom % 6) == 0) ? ~i_mask : i_mask;
            nx = (($urandom % 4) == 0) ? ~x_mask : x_mask;
            nq = (($urandom % 8) == 0);
            cyc(ni, nx, nq);
        end
        cyc(0, 0, 0); cyc(0, 0, 0);

        // R8: saturation, I high from first edge after reset
        @(negedge clk); rst_n = 1'b0; i_mask = 1'b1; x_mask = 1'b0; query = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (70000) cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0); cyc(0, 0, 0);
        chk("R8 i_last saturated", i_last, ALL1);
        chk("R8 i_max saturated", i_max, ALL1);
        chk("R8 i_min shows max", i_min, ALL1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule